// File: doc/BRIEF.md
# Interrupt Router Register Window

This block is the software-facing register file of an I/O interrupt router. Two bus offsets expose the whole space: an index register at byte offset 0x00 picks an internal register, and a 32-bit data window at byte offset 0x10 reads or writes the register that the index points at. Behind the window sit an identification register, a read-only version register, an arbitration register, and one redirection entry per input line. Each entry takes two indices: the low word at 0x10 + 2n and the high word at 0x10 + 2n + 1.

The stored configuration of every line goes straight out to the delivery logic on flat per-line buses. Those buses carry the vector, delivery mode, destination mode, polarity, trigger mode, mask and destination. The delivery logic returns two status bits per line, remote IRR and delivery status. Software sees both bits in the low word but cannot write them. A read request returns its data one cycle later, marked by a valid strobe.

Top module: `irq_route_regs`

## Requirements
- R1: After reset the index register reads 0 and the ID register reads 0. Every redirection entry has its mask bit (low word bit 16, port `cfg_mask`) set and all other stored fields cleared, so an untouched low word reads 0x00010000.
- R2: Only bits 27:24 of the ID register (index 0x00) are writable. All other bits read 0 after any write.
- R3: The version register (index 0x01) reads {8'h00, NUM_LINES-1, 8'h00, VERSION} and ignores every write.
- R4: The arbitration register (index 0x02) always reads the same value as the ID register, and writes to it are ignored.
- R5: A low-word write stores vector [7:0], delivery mode [10:8], destination mode [11], polarity [13], trigger mode [15] (1 = level) and mask [16], and drives them onto that line's configuration ports from the next cycle on. Read-back of bits 31:17 is zero.
- R6: Low-word bit 14 reads that line's live `remote_irr_in` and bit 12 its live `deliv_busy_in`. Written values for these bits are discarded, even when the status input changes in the same cycle as the write.
- R7: A high-word write stores only the destination in bits [31:24], and the rest of the high word reads 0. The write leaves the low-word fields and their outputs untouched.
- R8: Reads of unimplemented indices (0x03 to 0x0F and indices beyond the last entry) or of bus offsets other than 0x00 and 0x10 return 0. Writes to them change no state.
- R9: A read request returns `rd_data` with `rd_valid` high exactly one cycle later. `rd_valid` is low in every other cycle.
- R10: A read of bus offset 0x00 returns the current index in bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset (0x00 index, 0x10 data window) |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| remote_irr_in | input | NUM_LINES | Per-line remote IRR from delivery logic |
| deliv_busy_in | input | NUM_LINES | Per-line delivery status from delivery logic |
| cfg_vector | output | NUM_LINES*8 | Per-line vector |
| cfg_dmode | output | NUM_LINES*3 | Per-line delivery mode |
| cfg_dest_log | output | NUM_LINES | Per-line destination mode (1 = logical) |
| cfg_polarity | output | NUM_LINES | Per-line input polarity |
| cfg_trig_level | output | NUM_LINES | Per-line trigger mode (1 = level) |
| cfg_mask | output | NUM_LINES | Per-line mask |
| cfg_dest | output | NUM_LINES*8 | Per-line destination |

## Verification
Two things can fall in the same cycle: a software write to a line's low word and a change of that line's remote IRR input. The bench raises `remote_irr_in` on the very edge that commits a low-word write whose bit 14 is clear. It then reads the entry back and expects the written configuration together with bit 14 set. After the input drops, a second read must show bit 14 clear while the configuration is unchanged. A high-word write is also checked against the live low-word outputs, which must hold their values across that write.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam logic [7:0] OFS_INDEX  = 8'h00;
  localparam logic [7:0] OFS_WINDOW = 8'h10;

  localparam logic [7:0] IX_ID      = 8'h00;
  localparam logic [7:0] IX_VER     = 8'h01;
  localparam logic [7:0] IX_ARB     = 8'h02;
  localparam logic [7:0] IX_TABLE   = 8'h10;

  typedef struct packed {
    logic [7:0] vector;
    logic [2:0] dmode;
    logic       dest_log;
    logic       polarity;
    logic       trig_level;
    logic       mask;
    logic [7:0] dest;
  } line_cfg_t;

  function automatic logic [31:0] pack_low(input line_cfg_t c, input logic irr,
                                           input logic busy);
    return {15'd0, c.mask, c.trig_level, irr, c.polarity, busy, c.dest_log,
            c.dmode, c.vector};
  endfunction

  function automatic logic [31:0] pack_high(input line_cfg_t c);
    return {c.dest, 24'd0};
  endfunction

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
  import irq_route_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter int LINE_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [7:0]        req_addr,
  input  logic [7:0]        idx_wdata,
  output logic [7:0]        cur_index,
  output logic              win_wr,
  output logic              id_wr,
  output logic              entry_hit,
  output logic              entry_hi,
  output logic [LINE_W-1:0] entry_num
);

  logic [7:0] index_q, index_d;
  logic       index_en;
  logic [7:0] tbl_ofs;

  assign index_en = req_valid && req_write && (req_addr == OFS_INDEX);

  always_comb begin
    index_d = index_q;
    if (index_en) index_d = idx_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) index_q <= 8'h00;
    else        index_q <= index_d;
  end

  assign cur_index = index_q;
  assign win_wr    = req_valid && req_write && (req_addr == OFS_WINDOW);
  assign id_wr     = win_wr && (index_q == IX_ID);

  assign tbl_ofs   = index_q - IX_TABLE;
  assign entry_hit = (index_q >= IX_TABLE) && ({1'b0, tbl_ofs[7:1]} < 8'(NUM_LINES));
  assign entry_hi  = tbl_ofs[0];
  assign entry_num = tbl_ofs[LINE_W:1];

endmodule

// File: rtl/irq_route_ident.sv
module irq_route_ident #(
  parameter int         NUM_LINES = 24,
  parameter logic [7:0] VERSION   = 8'h20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        id_wr,
  input  logic [3:0]  id_wdata,
  output logic [31:0] id_word,
  output logic [31:0] ver_word,
  output logic [31:0] arb_word
);

  localparam logic [7:0] MAX_ENTRY = 8'(NUM_LINES - 1);

  logic [3:0] id_q, id_d;

  always_comb begin
    id_d = id_q;
    if (id_wr) id_d = id_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) id_q <= 4'h0;
    else        id_q <= id_d;
  end

  assign id_word  = {4'h0, id_q, 24'h0};
  assign arb_word = {4'h0, id_q, 24'h0};
  assign ver_word = {8'h00, MAX_ENTRY, 8'h00, VERSION};

endmodule

// File: rtl/irq_route_entry.sv
module irq_route_entry
  import irq_route_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_lo,
  input  logic       wr_hi,
  input  logic [7:0] lo_vector,
  input  logic [2:0] lo_dmode,
  input  logic       lo_dest_log,
  input  logic       lo_polarity,
  input  logic       lo_trig,
  input  logic       lo_mask,
  input  logic [7:0] hi_dest,
  output line_cfg_t  cfg
);

  line_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_lo) begin
      cfg_d.vector     = lo_vector;
      cfg_d.dmode      = lo_dmode;
      cfg_d.dest_log   = lo_dest_log;
      cfg_d.polarity   = lo_polarity;
      cfg_d.trig_level = lo_trig;
      cfg_d.mask       = lo_mask;
    end
    if (wr_hi) cfg_d.dest = hi_dest;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      cfg_q.mask <= 1'b1;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int         NUM_LINES = 24,
  parameter logic [7:0] VERSION   = 8'h20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [7:0]             req_addr,
  input  logic [31:0]            req_wdata,
  output logic                   rd_valid,
  output logic [31:0]            rd_data,
  input  logic [NUM_LINES-1:0]   remote_irr_in,
  input  logic [NUM_LINES-1:0]   deliv_busy_in,
  output logic [NUM_LINES*8-1:0] cfg_vector,
  output logic [NUM_LINES*3-1:0] cfg_dmode,
  output logic [NUM_LINES-1:0]   cfg_dest_log,
  output logic [NUM_LINES-1:0]   cfg_polarity,
  output logic [NUM_LINES-1:0]   cfg_trig_level,
  output logic [NUM_LINES-1:0]   cfg_mask,
  output logic [NUM_LINES*8-1:0] cfg_dest
);

  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  logic [7:0]        cur_index;
  logic              win_wr, id_wr, entry_hit, entry_hi;
  logic [LINE_W-1:0] entry_num;
  logic [31:0]       id_word, ver_word, arb_word;
  line_cfg_t         line_cfg [NUM_LINES];
  logic [31:0]       lo_word  [NUM_LINES];
  logic [31:0]       hi_word  [NUM_LINES];
  logic [31:0]       win_rdata, rd_data_d;
  logic              rd_req;
  logic              unused_wdata_bits;

  assign unused_wdata_bits = ^{req_wdata[23:17], req_wdata[14], req_wdata[12]};

  irq_route_decode #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .idx_wdata (req_wdata[7:0]),
    .cur_index (cur_index),
    .win_wr    (win_wr),
    .id_wr     (id_wr),
    .entry_hit (entry_hit),
    .entry_hi  (entry_hi),
    .entry_num (entry_num)
  );

  irq_route_ident #(.NUM_LINES(NUM_LINES), .VERSION(VERSION)) u_ident (
    .clk      (clk),
    .rst_n    (rst_n),
    .id_wr    (id_wr),
    .id_wdata (req_wdata[27:24]),
    .id_word  (id_word),
    .ver_word (ver_word),
    .arb_word (arb_word)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic sel_line;
    assign sel_line = win_wr && entry_hit && (entry_num == LINE_W'(g));

    irq_route_entry u_entry (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_lo       (sel_line && !entry_hi),
      .wr_hi       (sel_line && entry_hi),
      .lo_vector   (req_wdata[7:0]),
      .lo_dmode    (req_wdata[10:8]),
      .lo_dest_log (req_wdata[11]),
      .lo_polarity (req_wdata[13]),
      .lo_trig     (req_wdata[15]),
      .lo_mask     (req_wdata[16]),
      .hi_dest     (req_wdata[31:24]),
      .cfg         (line_cfg[g])
    );

    assign lo_word[g] = pack_low(line_cfg[g], remote_irr_in[g], deliv_busy_in[g]);
    assign hi_word[g] = pack_high(line_cfg[g]);

    assign cfg_vector[g*8 +: 8]  = line_cfg[g].vector;
    assign cfg_dmode[g*3 +: 3]   = line_cfg[g].dmode;
    assign cfg_dest_log[g]       = line_cfg[g].dest_log;
    assign cfg_polarity[g]       = line_cfg[g].polarity;
    assign cfg_trig_level[g]     = line_cfg[g].trig_level;
    assign cfg_mask[g]           = line_cfg[g].mask;
    assign cfg_dest[g*8 +: 8]    = line_cfg[g].dest;
  end

  always_comb begin
    win_rdata = 32'h0;
    if (entry_hit) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (entry_num == LINE_W'(i)) win_rdata = entry_hi ? hi_word[i] : lo_word[i];
      end
    end else begin
      case (cur_index)
        IX_ID:   win_rdata = id_word;
        IX_VER:  win_rdata = ver_word;
        IX_ARB:  win_rdata = arb_word;
        default: win_rdata = 32'h0;
      endcase
    end
  end

  assign rd_req = req_valid && !req_write;

  always_comb begin
    rd_data_d = rd_data;
    if (rd_req) begin
      if (req_addr == OFS_INDEX)       rd_data_d = {24'h0, cur_index};
      else if (req_addr == OFS_WINDOW) rd_data_d = win_rdata;
      else                             rd_data_d = 32'h0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 32'h0;
    end else begin
      rd_valid <= rd_req;
      rd_data  <= rd_data_d;
    end
  end

endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk #(
  parameter int         NUM_LINES = 24,
  parameter logic [7:0] VERSION   = 8'h20
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_write,
  input logic [7:0]             req_addr,
  input logic [7:0]             cur_index,
  input logic                   rd_valid,
  input logic [31:0]            rd_data,
  input logic [NUM_LINES*8-1:0] cfg_vector,
  input logic [NUM_LINES-1:0]   cfg_mask,
  input logic [NUM_LINES*8-1:0] cfg_dest
);

  localparam logic [31:0] VER_EXP = {8'h00, 8'(NUM_LINES - 1), 8'h00, VERSION};

  logic rd_req, win_write, high_write, stray_write;

  assign rd_req      = req_valid && !req_write;
  assign win_write   = req_valid && req_write && (req_addr == 8'h10);
  assign high_write  = win_write && (cur_index >= 8'h10) && cur_index[0];
  assign stray_write = req_valid && req_write && (req_addr != 8'h00) && (req_addr != 8'h10);

  assert_read_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  assert_no_idle_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  assert_version_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && req_addr == 8'h10 && cur_index == 8'h01) |=> (rd_data == VER_EXP));

  assert_high_keeps_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    high_write |=> ($stable(cfg_vector) && $stable(cfg_mask)));

  assert_stray_write_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stray_write |=> ($stable(cur_index) && $stable(cfg_mask) && $stable(cfg_dest)));

  assert_cfg_only_by_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !win_write |=> ($stable(cfg_mask) && $stable(cfg_vector) && $stable(cfg_dest)));

endmodule

bind irq_route_regs irq_route_regs_chk #(.NUM_LINES(NUM_LINES), .VERSION(VERSION)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .cur_index  (cur_index),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .cfg_vector (cfg_vector),
  .cfg_mask   (cfg_mask),
  .cfg_dest   (cfg_dest)
);

// File: tb/irq_route_regs_test.sv
module irq_route_regs_test;

  localparam int NL = 24;

  logic          clk;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [7:0]    req_addr;
  logic [31:0]   req_wdata;
  logic          rd_valid;
  logic [31:0]   rd_data;
  logic [NL-1:0] remote_irr_in, deliv_busy_in;
  logic [NL*8-1:0] cfg_vector, cfg_dest;
  logic [NL*3-1:0] cfg_dmode;
  logic [NL-1:0] cfg_dest_log, cfg_polarity, cfg_trig_level, cfg_mask;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  irq_route_regs #(.NUM_LINES(NL), .VERSION(8'h20)) uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .req_addr       (req_addr),
    .req_wdata      (req_wdata),
    .rd_valid       (rd_valid),
    .rd_data        (rd_data),
    .remote_irr_in  (remote_irr_in),
    .deliv_busy_in  (deliv_busy_in),
    .cfg_vector     (cfg_vector),
    .cfg_dmode      (cfg_dmode),
    .cfg_dest_log   (cfg_dest_log),
    .cfg_polarity   (cfg_polarity),
    .cfg_trig_level (cfg_trig_level),
    .cfg_mask       (cfg_mask),
    .cfg_dest       (cfg_dest)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [7:0]  idx;
    logic [31:0] val;
    logic [3:0]  req;
  } step_t;

  localparam int NSTEP = 26;
  localparam step_t STEPS [NSTEP] = '{
    '{1'b0, 8'h00, 32'h00000000, 4'd1},  // R1 ID reset
    '{1'b1, 8'h00, 32'hFFFFFFFF, 4'd2},  // R2
    '{1'b0, 8'h00, 32'h0F000000, 4'd2},  // R2 only 27:24 stick
    '{1'b0, 8'h02, 32'h0F000000, 4'd4},  // R4 mirror
    '{1'b1, 8'h02, 32'h00000000, 4'd4},  // R4 write ignored
    '{1'b0, 8'h02, 32'h0F000000, 4'd4},
    '{1'b0, 8'h01, 32'h00170020, 4'd3},  // R3
    '{1'b1, 8'h01, 32'hFFE8FFDF, 4'd3},
    '{1'b0, 8'h01, 32'h00170020, 4'd3},
    '{1'b1, 8'h00, 32'h05000000, 4'd4},
    '{1'b0, 8'h02, 32'h05000000, 4'd4},
    '{1'b0, 8'h10, 32'h00010000, 4'd1},  // R1 masked entry
    '{1'b1, 8'h10, 32'hFFFFFFFF, 4'd5},  // R5
    '{1'b0, 8'h10, 32'h0001AFFF, 4'd5},
    '{1'b1, 8'h11, 32'hFFFFFFFF, 4'd7},  // R7
    '{1'b0, 8'h11, 32'hFF000000, 4'd7},
    '{1'b0, 8'h10, 32'h0001AFFF, 4'd7},
    '{1'b0, 8'h03, 32'h00000000, 4'd8},  // R8
    '{1'b1, 8'h05, 32'hFFFFFFFF, 4'd8},
    '{1'b0, 8'h05, 32'h00000000, 4'd8},
    '{1'b0, 8'h40, 32'h00000000, 4'd8},
    '{1'b1, 8'h3E, 32'h00008123, 4'd5},  // last line
    '{1'b0, 8'h3E, 32'h00008123, 4'd5},
    '{1'b1, 8'h3F, 32'hAB000000, 4'd7},
    '{1'b0, 8'h3F, 32'hAB000000, 4'd7},
    '{1'b0, 8'h3E, 32'h00008123, 4'd7}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] addr, input logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = addr; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] addr, output logic [31:0] data,
                          output logic vld);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
    data = rd_data;
    vld  = rd_valid;
  endtask

  initial begin
    logic [31:0] rv;
    logic        vl;
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = 8'h00; req_wdata = 32'h0;
    remote_irr_in = '0; deliv_busy_in = '0;
    repeat (3) @(negedge clk);
    check("R1 mask outputs at reset", 32'(cfg_mask), 32'(24'hFFFFFF));
    check("R1 vector outputs at reset", cfg_vector[31:0], 32'h0);
    rst_n = 1'b1;

    bus_read(8'h00, rv, vl);
    check("R1 index reset", rv, 32'h0);
    check("R9 valid after read", 32'(vl), 32'd1);
    @(negedge clk);
    check("R9 valid drops", 32'(rd_valid), 32'd0);

    for (int s = 0; s < NSTEP; s++) begin
      bus_write(8'h00, {24'h0, STEPS[s].idx});
      if (STEPS[s].wr) begin
        bus_write(8'h10, STEPS[s].val);
      end else begin
        bus_read(8'h10, rv, vl);
        check($sformatf("R%0d step %0d", STEPS[s].req, s), rv, STEPS[s].val);
      end
    end

    // R5 configuration outputs of line 3
    bus_write(8'h00, 32'h16);
    bus_write(8'h10, 32'h00002B42);
    check("R5 vector port", 32'(cfg_vector[24 +: 8]), 32'h42);
    check("R5 dmode port", 32'(cfg_dmode[9 +: 3]), 32'd3);
    check("R5 destmode/pol/trig/mask ports",
          {28'h0, cfg_dest_log[3], cfg_polarity[3], cfg_trig_level[3], cfg_mask[3]},
          32'hC);
    check("R5 neighbour line mask", 32'(cfg_mask[4]), 32'd1);

    deliv_busy_in[3] = 1'b1; remote_irr_in[3] = 1'b1;
    bus_read(8'h10, rv, vl);
    check("R6 live status bits", rv, 32'h00007B42);
    deliv_busy_in[3] = 1'b0; remote_irr_in[3] = 1'b0;

    // R6 status change in the same cycle as a low-word write
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h10; req_wdata = 32'h00008B42;
    remote_irr_in[3] = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R6 trig port after write", 32'(cfg_trig_level[3]), 32'd1);
    bus_read(8'h10, rv, vl);
    check("R6 concurrent write keeps status", rv, 32'h0000CB42);
    remote_irr_in[3] = 1'b0;
    bus_read(8'h10, rv, vl);
    check("R6 status follows input", rv, 32'h00008B42);

    // R7 high word of line 3
    bus_write(8'h00, 32'h17);
    bus_write(8'h10, 32'h7E00FFFF);
    check("R7 dest port", 32'(cfg_dest[24 +: 8]), 32'h7E);
    check("R7 vector port kept", 32'(cfg_vector[24 +: 8]), 32'h42);
    bus_read(8'h10, rv, vl);
    check("R7 high read", rv, 32'h7E000000);
    bus_write(8'h00, 32'h16);
    bus_read(8'h10, rv, vl);
    check("R7 low kept", rv, 32'h00008B42);

    // R10 and R8 offsets
    bus_write(8'h00, 32'h2A);
    bus_read(8'h00, rv, vl);
    check("R10 index readback", rv, 32'h2A);
    bus_write(8'h08, 32'h55);
    bus_read(8'h00, rv, vl);
    check("R8 stray write leaves index", rv, 32'h2A);
    bus_read(8'h08, rv, vl);
    check("R8 stray offset reads zero", rv, 32'h0);
    check("R9 valid on stray read", 32'(vl), 32'd1);
    bus_write(8'h10, 32'h0);
    check("R9 no valid after write", 32'(rd_valid), 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule